// File: doc/BRIEF.md
# DRAM refresh scheduler

This block keeps every row of an asynchronous DRAM refreshed within its retention period. A free-running interval timer adds one owed refresh every `INTERVAL_CYC` clock cycles. With a 100 MHz clock, 1560 cycles gives about 15.6 us, which spreads 2048 rows over 32 ms. A low-power part with a 128 ms budget would use about 6250 cycles. Owed refreshes pile up in a small saturating counter, so a burst of traffic can put refresh off for a while. When the counter is full, the scheduler raises an urgent flag. The access controller must then grant the refresh before it starts any new access.

The refresh style is picked by `mode_ras_only`.

- **Strobe-order refresh (mode low):** column strobe before row strobe. The DRAM uses its own internal row counter, so no address is needed.
- **Row-strobe-only refresh (mode high):** the scheduler puts an 11-bit row from its own counter on the address pins while only the row strobe pulses. This counter steps once per completed refresh of this style and wraps.
- **Hidden refresh (strobe-order mode only):** when a read finishes with the column strobe still low, the scheduler can use that moment. The row strobe is cycled again and the read data stays valid. No grant is needed.

The scheduler starts one refresh at a time and waits for the command sequencer to report that it has finished.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ref_req`, `ref_urgent` and `ref_issue` are 0 and `ref_row` is 0.
- R2: The first refresh becomes owed after `INTERVAL_CYC` clock edges from reset. Another becomes owed every `INTERVAL_CYC` cycles after that, whether or not refreshes are being issued.
- R3: The owed count never exceeds `MAX_PEND`; a tick at the limit is lost. A tick and an issue in the same cycle leave the count unchanged.
- R4: `ref_req` is 1 exactly when at least one refresh is owed and no refresh is in flight.
- R5: `ref_urgent` is 1 exactly when the owed count equals `MAX_PEND`.
- R6: `ref_issue` pulses in a cycle where `ref_req` is 1 and `ref_gnt` is 1. In any cycle where `ref_req` is 0, `ref_gnt` is ignored: there is no issue and the owed count is unchanged.
- R7: During `ref_issue`, `ref_kind` reads 2'b00 for strobe-order refresh (mode 0), 2'b01 for row-strobe-only refresh (mode 1) and 2'b10 for hidden refresh.
- R8: With mode 0, `rd_done` while `ref_req` is 1 issues a hidden refresh (kind 2'b10) without a grant, and it wins over a grant in the same cycle. With mode 1, `rd_done` is ignored.
- R9: `ref_row` advances by one after the `ref_done` of a row-strobe-only refresh and wraps from 2047 to 0. Completion of other refresh kinds leaves it unchanged.
- R10: After an issue, no further issue occurs and `ref_req` stays 0 until `ref_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ras_only | input | 1 | 1: row-strobe-only refresh with external row; 0: strobe-order refresh |
| ref_gnt | input | 1 | Access controller grants the refresh |
| rd_done | input | 1 | A read just completed with the column strobe still low |
| ref_done | input | 1 | Sequencer finished the refresh in flight |
| ref_req | output | 1 | Refresh owed and none in flight |
| ref_urgent | output | 1 | Owed count at its limit |
| ref_issue | output | 1 | One-cycle start of a refresh |
| ref_kind | output | 2 | Kind of the refresh being started |
| ref_row | output | ROW_W | Row for row-strobe-only refresh |

## Verification
The timer tick and a refresh issue can land in the same cycle. The owed count must then stay put, and at the limit the tick must be dropped rather than wrap the count. A grant and a read completion can also coincide, and the hidden path must win only in strobe-order mode.

Random grants, read completions, done pulses and mode changes run against a short interval and a small limit, so these collisions happen often. Each cycle is compared with a bench model built from the requirements. Directed phases starve the scheduler into saturation, and then sweep the row counter through its wrap.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [1:0] {
        RFK_STROBE  = 2'b00,
        RFK_ROWONLY = 2'b01,
        RFK_HIDDEN  = 2'b10
    } rf_kind_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == LAST);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr #(
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pend_nz,
    output logic pend_full
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] FULL = PW'(MAX_PEND);

    typedef struct packed {
        logic [PW-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case ({tick, take})
            2'b10: if (st_q.pend != FULL) st_d.pend = st_q.pend + 1'b1;
            2'b01: if (st_q.pend != '0)   st_d.pend = st_q.pend - 1'b1;
            default: ;
        endcase
        pend_nz   = (st_q.pend != '0);
        pend_full = (st_q.pend == FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    tick_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && !pend_full) |=> ((st_q.pend - $past(st_q.pend)) == PW'(1)));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && pend_full) |=> pend_full);
    // R3
    tick_take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && take) |=> $stable(st_q.pend));
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
    } row_t;

    row_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) st_d.row = st_q.row + 1'b1;
        row = st_q.row;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((row - $past(row)) == ROW_W'(1)));
    // R9
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rfs_pkg::*;
#(
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 4,
    parameter int ROW_W        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ras_only,
    input  logic             ref_gnt,
    input  logic             rd_done,
    input  logic             ref_done,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             ref_issue,
    output logic [1:0]       ref_kind,
    output logic [ROW_W-1:0] ref_row
);
    typedef struct packed {
        logic busy;
        logic row_style;
    } ctl_t;

    ctl_t     st_d, st_q;
    logic     tick, pend_nz, pend_full, hidden_ok, can_go, row_adv;
    rf_kind_e kind;

    rfs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    rfs_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(ref_issue),
        .pend_nz(pend_nz), .pend_full(pend_full));

    rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(ref_row));

    always_comb begin
        st_d      = st_q;
        hidden_ok = !mode_ras_only && rd_done;
        can_go    = pend_nz && !st_q.busy;
        ref_issue = can_go && (ref_gnt || hidden_ok);
        if (hidden_ok)          kind = RFK_HIDDEN;
        else if (mode_ras_only) kind = RFK_ROWONLY;
        else                    kind = RFK_STROBE;
        row_adv = st_q.busy && ref_done && st_q.row_style;
        if (ref_issue) begin
            st_d.busy      = 1'b1;
            st_d.row_style = (kind == RFK_ROWONLY);
        end else if (ref_done) begin
            st_d.busy = 1'b0;
        end
        ref_req    = can_go;
        ref_urgent = pend_full;
        ref_kind   = kind;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue |=> (!ref_req && !ref_issue));
    // R7
    row_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_issue && mode_ras_only) |-> (ref_kind == RFK_ROWONLY));
    // R8
    hidden_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_issue && !mode_ras_only && rd_done) |-> (ref_kind == RFK_HIDDEN));
    // R5
    urgent_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req || st_q.busy));
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int IV   = 8;
    localparam int MAXP = 3;
    localparam int RW   = 11;

    logic clk = 0, rst_n = 0;
    logic mode = 0, gnt = 0, rd = 0, dn = 0;
    logic req, urg, iss;
    logic [1:0]    kind;
    logic [RW-1:0] row;

    int n_chk = 0, n_fail = 0, wraps = 0, collide = 0;
    int m_cnt = 0, m_pend = 0, m_row = 0;
    bit m_busy = 0, m_rs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sched #(.INTERVAL_CYC(IV), .MAX_PEND(MAXP), .ROW_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_ras_only(mode), .ref_gnt(gnt),
        .rd_done(rd), .ref_done(dn), .ref_req(req), .ref_urgent(urg),
        .ref_issue(iss), .ref_kind(kind), .ref_row(row));

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int exp_kind(bit md, bit r);
        if (!md && r) return 2;
        return md ? 1 : 0;
    endfunction

    // one cycle: inputs driven at negedge, compared, model advanced at posedge
    task automatic step(input bit g, input bit r, input bit d, input bit md);
        bit e_req, e_iss, tk;
        gnt = g; rd = r; dn = d; mode = md;
        #1;
        e_req = (m_pend > 0) && !m_busy;
        e_iss = e_req && (g || (!md && r));
        chk(req == e_req, "R4 ref_req", req, e_req);
        chk(urg == (m_pend == MAXP), "R5 ref_urgent", urg, m_pend == MAXP);
        chk(iss == e_iss, "R6/R10 ref_issue", iss, e_iss);
        if (e_iss) chk(kind == exp_kind(md, r), "R7/R8 ref_kind", kind, exp_kind(md, r));
        chk(row == m_row, "R9 ref_row", row, m_row);
        tk = (m_cnt == IV - 1);
        if (tk && e_iss) collide++;
        @(posedge clk);
        m_cnt = tk ? 0 : m_cnt + 1;
        if (tk && !e_iss && m_pend < MAXP) m_pend++;
        else if (!tk && e_iss) m_pend--;
        if (m_busy && d && m_rs) begin
            if (m_row == 2047) wraps++;
            m_row = (m_row + 1) % 2048;
        end
        if (e_iss) begin
            m_busy = 1; m_rs = (exp_kind(md, r) == 1);
        end else if (d) m_busy = 0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req == 0, "R1 req in reset", req, 0);
        chk(urg == 0, "R1 urgent in reset", urg, 0);
        chk(iss == 0, "R1 issue in reset", iss, 0);
        chk(row == 0, "R1 row in reset", row, 0);
        rst_n = 1;
        // R2 first tick after IV edges: req low for IV cycles, high after
        for (int i = 0; i < IV; i++) step(1, 0, 0, 0);
        chk(req == 1 && m_pend == 1, "R2 first owed refresh", req, 1);
        // R6 grant with nothing owed is ignored
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        for (int i = 0; i < IV - 2; i++) step(1, 1, 0, 0);
        chk(m_busy == 0, "R6 grant ignored idle", iss, 0);
        // R3/R5 starvation to saturation and beyond
        for (int i = 0; i < IV * (MAXP + 3); i++) step(0, 0, 0, 1);
        chk(urg == 1, "R5 urgent at limit", urg, 1);
        // R8 rd_done ignored in row-only mode
        step(0, 1, 0, 1);
        chk(m_pend == MAXP, "R8 rd_done ignored mode1", m_pend, MAXP);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit md;
            md = ((i / 150) % 2) == 1;
            step(($urandom % 10) < 3, ($urandom % 10) < 2,
                 m_busy && (($urandom % 10) < 4), md);
        end
        chk(collide > 0, "R3 tick/issue collisions seen", collide, 1);
        // R9 wrap sweep
        for (int i = 0; i < 2100 * IV && wraps == 0; i++) step(1, 0, m_busy, 1);
        for (int i = 0; i < 4 * IV; i++) step(1, 0, m_busy, 1);
        chk(wraps > 0, "R9 row wrap seen", wraps, 1);
        // R9 strobe-order completions do not move row
        for (int i = 0; i < 4 * IV; i++) step(1, 0, m_busy, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule